// File: doc/BRIEF.md
# Out-of-Order Scatter Accumulator

This block sums a stream of floating-point contributions into a small on-chip array, one word per address. A typical use is an edge loop in a mesh solver, where each edge adds a partial residual into the sums of its two end nodes. Every beat carries an address and a binary32 value. The block reads the current sum for that address and sends the pair through a pipelined adder. The adder result is written back to the same word. The input takes one beat per clock, even though a word stays in the adder for several cycles before its new value is stored.

A beat whose address is still in the adder cannot read a valid sum yet. Such a beat is not stalled and not dropped. It moves into a short holding queue. Later it re-enters the adder in a cycle that the input stream leaves free, once its address is no longer in flight. If neither the input nor the head of the queue can enter safely, that adder slot stays empty. While the flush input is held high, the input is closed and the queue and adder drain. The done flag then rises, and the final sums can be read out through a registered read port.

Top module: `scatter_accum`

## Requirements
- R1: `in_ready_o` is high in every cycle in which the holding queue has fewer than QDEPTH (default 8) entries and `flush_i` is low. A stream of distinct addresses is therefore accepted at one beat per clock, with no stall cycle.
- R2: After reset, each array word holds binary32 +0.0. Once a flush completes, each word holds the sum of every accepted value for its address. The adder handles non-negative normal numbers and zero, and truncates the result. Sums of integer-valued inputs below 2^24 are therefore exact.
- R3: An update never enters the adder while its address is held in any of the LAT (default 3) adder stages. The stage being written back counts as one of those stages.
- R4: An accepted beat whose address is in flight is placed in the holding queue and is never lost. When the queue holds QDEPTH entries, `in_ready_o` is low.
- R5: In a cycle with no accepted beat, the queue head enters the adder if its address is not in flight.
- R6: When no accepted beat and no queued entry can enter the adder, the adder slot for that cycle is left empty (a bubble).
- R7: While `flush_i` is high, `in_ready_o` is low. `done_o` is high exactly when `flush_i` is high, the queue is empty and no adder stage is occupied.
- R8: When no update is entering the adder, `rd_data_o` shows the word at `rd_addr_i` one clock after that address is presented.
- R9: Reset empties the queue and the adder pipeline. All array words are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Input beat present |
| in_ready_o | output | 1 | Block can take a beat this cycle |
| in_addr_i | input | AW | Target word of the beat |
| in_data_i | input | 32 | binary32 value to add |
| flush_i | input | 1 | Close the input and drain (level) |
| done_o | output | 1 | Drain complete while flushing |
| rd_addr_i | input | AW | Readout word address |
| rd_data_o | output | 32 | Registered readout data |

## Verification
The bench first drives a mixed stream from a table of beats. The stream has scattered repeats and short same-address pairs, so the parking and replay paths run between hazard-free beats. The bench compares every final sum against running totals it keeps itself. Next, a run over sixteen distinct addresses must be accepted without a single stall, which separates true hazards from a scheduler that stalls too often. Last, a long burst to one word must fill the queue far enough to pull ready low, with the bench checking that nothing is lost. A flush raised right after that burst must hold done low until replay has drained the queue.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

    typedef logic [31:0] f32_t;

    // Adds two non-negative binary32 values; zero/denormal inputs count as zero,
    // result is truncated (no rounding increment).
    function automatic f32_t fadd_pos(input f32_t x, input f32_t y);
        logic [7:0]  e_big, e_sml, shift;
        logic [23:0] m_big, m_sml, m_aln;
        logic [24:0] sum;
        f32_t        res;
        if (x[30:23] == 8'd0) return y;
        if (y[30:23] == 8'd0) return x;
        if (x[30:23] >= y[30:23]) begin
            e_big = x[30:23]; m_big = {1'b1, x[22:0]};
            e_sml = y[30:23]; m_sml = {1'b1, y[22:0]};
        end else begin
            e_big = y[30:23]; m_big = {1'b1, y[22:0]};
            e_sml = x[30:23]; m_sml = {1'b1, x[22:0]};
        end
        shift = e_big - e_sml;
        m_aln = (shift > 8'd24) ? 24'd0 : (m_sml >> shift);
        sum   = {1'b0, m_big} + {1'b0, m_aln};
        if (sum[24]) res = {1'b0, e_big + 8'd1, sum[23:1]};
        else         res = {1'b0, e_big, sum[22:0]};
        return res;
    endfunction

endpackage

// File: rtl/sacc_fifo.sv
module sacc_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 36
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       push_i,
    input  logic [W-1:0]               wdata_i,
    input  logic                       pop_i,
    output logic [W-1:0]               rdata_o,
    output logic                       empty_o,
    output logic                       full_o,
    output logic [$clog2(DEPTH):0]     count_o
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [PW-1:0]           rp;
        logic [PW-1:0]           wp;
        logic [PW:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.slot[st_q.wp] = wdata_i;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (pop_i) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + (PW + 1)'(push_i) - (PW + 1)'(pop_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdata_o = st_q.slot[st_q.rp];
    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == (PW + 1)'(DEPTH));
    assign count_o = st_q.cnt;

endmodule

// File: rtl/sacc_fadd.sv
module sacc_fadd
    import sacc_pkg::*;
#(
    parameter int AW  = 4,
    parameter int LAT = 3
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     in_v_i,
    input  logic [AW-1:0]            in_a_i,
    input  f32_t                     op_x_i,
    input  f32_t                     op_y_i,
    output logic [LAT-1:0]           stg_v_o,
    output logic [LAT-1:0][AW-1:0]   stg_a_o,
    output logic                     out_v_o,
    output logic [AW-1:0]            out_a_o,
    output f32_t                     out_s_o
);
    typedef struct packed {
        logic [LAT-1:0]          v;
        logic [LAT-1:0][AW-1:0]  a;
        logic [LAT-1:0][31:0]    s;
    } pipe_st_t;

    pipe_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.v[0] = in_v_i;
        st_d.a[0] = in_a_i;
        st_d.s[0] = fadd_pos(op_x_i, op_y_i);
        for (int k = 1; k < LAT; k++) begin
            st_d.v[k] = st_q.v[k-1];
            st_d.a[k] = st_q.a[k-1];
            st_d.s[k] = st_q.s[k-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stg_v_o = st_q.v;
    assign stg_a_o = st_q.a;
    assign out_v_o = st_q.v[LAT-1];
    assign out_a_o = st_q.a[LAT-1];
    assign out_s_o = st_q.s[LAT-1];

endmodule

// File: rtl/scatter_accum.sv
module scatter_accum
    import sacc_pkg::*;
#(
    parameter int AW     = 4,
    parameter int LAT    = 3,
    parameter int QDEPTH = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          in_valid_i,
    output logic          in_ready_o,
    input  logic [AW-1:0] in_addr_i,
    input  logic [31:0]   in_data_i,
    input  logic          flush_i,
    output logic          done_o,
    input  logic [AW-1:0] rd_addr_i,
    output logic [31:0]   rd_data_o
);
    localparam int WORDS = 1 << AW;
    localparam int EW    = AW + 32;
    localparam int CW    = $clog2(QDEPTH) + 1;

    typedef struct packed {
        logic [31:0] rd_data;
    } top_st_t;

    top_st_t st_d, st_q;

    f32_t                   mem_q [WORDS];
    logic [LAT-1:0]         stg_v;
    logic [LAT-1:0][AW-1:0] stg_a;
    logic                   wb_v;
    logic [AW-1:0]          wb_a;
    f32_t                   wb_s;

    logic [EW-1:0]          head_e;
    logic [AW-1:0]          head_a;
    logic                   q_empty, q_full;
    logic [CW-1:0]          q_cnt;

    logic                   take_new, new_haz, head_haz;
    logic                   issue_v, issue_from_q, push, pop;
    logic [AW-1:0]          issue_a, mem_ra;
    f32_t                   issue_val;

    assign head_a     = head_e[EW-1:32];
    assign in_ready_o = !q_full && !flush_i;
    assign take_new   = in_valid_i && in_ready_o;

    always_comb begin
        new_haz  = 1'b0;
        head_haz = 1'b0;
        for (int k = 0; k < LAT; k++) begin
            if (stg_v[k] && stg_a[k] == in_addr_i) new_haz  = 1'b1;
            if (stg_v[k] && stg_a[k] == head_a)    head_haz = 1'b1;
        end
    end

    always_comb begin
        issue_from_q = !(take_new && !new_haz) && !q_empty && !head_haz;
        issue_v      = (take_new && !new_haz) || issue_from_q;
        push         = take_new && new_haz;
        pop          = issue_from_q;
        issue_a      = issue_from_q ? head_a : in_addr_i;
        issue_val    = issue_from_q ? head_e[31:0] : in_data_i;
        mem_ra       = issue_v ? issue_a : rd_addr_i;
        st_d         = st_q;
        if (!issue_v) st_d.rd_data = mem_q[mem_ra];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (wb_v) begin
            mem_q[wb_a] <= wb_s;
        end
    end

    sacc_fifo #(.DEPTH(QDEPTH), .W(EW)) i_park (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (push),
        .wdata_i ({in_addr_i, in_data_i}),
        .pop_i   (pop),
        .rdata_o (head_e),
        .empty_o (q_empty),
        .full_o  (q_full),
        .count_o (q_cnt)
    );

    sacc_fadd #(.AW(AW), .LAT(LAT)) i_fadd (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .in_v_i  (issue_v),
        .in_a_i  (issue_a),
        .op_x_i  (mem_q[mem_ra]),
        .op_y_i  (issue_val),
        .stg_v_o (stg_v),
        .stg_a_o (stg_a),
        .out_v_o (wb_v),
        .out_a_o (wb_a),
        .out_s_o (wb_s)
    );

    assign done_o    = flush_i && q_empty && (stg_v == '0);
    assign rd_data_o = st_q.rd_data;

endmodule

// File: rtl/sacc_checker.sv
module sacc_checker #(
    parameter int AW     = 4,
    parameter int LAT    = 3,
    parameter int QDEPTH = 8
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     in_valid_i,
    input logic                     in_ready_o,
    input logic                     flush_i,
    input logic                     done_o,
    input logic                     issue_v,
    input logic                     issue_from_q,
    input logic [AW-1:0]            issue_a,
    input logic [LAT-1:0]           stg_v,
    input logic [LAT-1:0][AW-1:0]   stg_a,
    input logic                     q_empty,
    input logic [$clog2(QDEPTH):0]  q_cnt
);
    localparam int CW = $clog2(QDEPTH) + 1;

    for (genvar k = 0; k < LAT; k++) begin : g_stage
        AST_NO_INFLIGHT_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (issue_v && stg_v[k]) |-> (stg_a[k] != issue_a)); // R3
    end

    AST_QUEUE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q_cnt <= CW'(QDEPTH)); // R4

    AST_PARK_NOT_LOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_ready_o && !(issue_v && !issue_from_q))
        |=> q_cnt == CW'($past(q_cnt) + CW'(1) - CW'($past(issue_from_q)))); // R4

    AST_REPLAY_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(in_valid_i && in_ready_o) && !q_empty && stg_v == '0)
        |-> (issue_v && issue_from_q)); // R5

    AST_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(in_valid_i && in_ready_o) && q_empty) |-> !issue_v); // R6

    AST_FLUSH_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |-> !in_ready_o); // R7

    AST_DONE_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (q_empty && stg_v == '0)); // R7

endmodule

bind scatter_accum sacc_checker #(.AW(AW), .LAT(LAT), .QDEPTH(QDEPTH)) i_sacc_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .in_ready_o   (in_ready_o),
    .flush_i      (flush_i),
    .done_o       (done_o),
    .issue_v      (issue_v),
    .issue_from_q (issue_from_q),
    .issue_a      (issue_a),
    .stg_v        (stg_v),
    .stg_a        (stg_a),
    .q_empty      (q_empty),
    .q_cnt        (q_cnt)
);

// File: tb/test_scatter_accum.sv
module test_scatter_accum;
    localparam int AW    = 4;
    localparam int WORDS = 1 << AW;
    localparam int NVEC  = 24;

    // stimulus table: {address, integer value}
    localparam logic [11:0] VEC [NVEC] = '{
        {4'd3, 8'd5},  {4'd7, 8'd11}, {4'd3, 8'd2},  {4'd3, 8'd9},
        {4'd0, 8'd1},  {4'd12, 8'd40},{4'd7, 8'd3},  {4'd15, 8'd200},
        {4'd15, 8'd100},{4'd1, 8'd7}, {4'd3, 8'd4},  {4'd9, 8'd63},
        {4'd9, 8'd1},  {4'd9, 8'd64}, {4'd2, 8'd17}, {4'd12, 8'd8},
        {4'd5, 8'd33}, {4'd0, 8'd255},{4'd7, 8'd6},  {4'd1, 8'd1},
        {4'd10, 8'd12},{4'd10, 8'd12},{4'd4, 8'd90}, {4'd3, 8'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [AW-1:0] in_addr = '0;
    logic [31:0]   in_data = '0;
    logic          flush = 1'b0;
    logic          done;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;

    int checks = 0;
    int failures = 0;
    int stalls = 0;
    int exp_sum [WORDS];

    always #4 clk = ~clk;

    scatter_accum i_scatter_accum (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .in_valid_i (in_valid),
        .in_ready_o (in_ready),
        .in_addr_i  (in_addr),
        .in_data_i  (in_data),
        .flush_i    (flush),
        .done_o     (done),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data)
    );

    function automatic logic [31:0] to_f32(input int n);
        int p;
        logic [31:0] sh;
        if (n == 0) return 32'd0;
        p = 0;
        for (int b = 0; b < 24; b++) if (n[b]) p = b;
        sh = 32'(n) << (23 - p);
        return {1'b0, 8'(127 + p), sh[22:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [AW-1:0] a, input int n);
        in_valid = 1'b1;
        in_addr  = a;
        in_data  = to_f32(n);
        while (!in_ready) begin
            stalls++;
            @(negedge clk);
        end
        @(negedge clk);
        exp_sum[a] += n;
    endtask

    task automatic flush_and_read(input string tag);
        int waited;
        in_valid = 1'b0;
        flush = 1'b1;
        #1;
        check("R7 ready low while flushing", 32'(in_ready), 32'd0);
        waited = 0;
        while (!done && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        check("R7 done reached", 32'(done), 32'd1);
        for (int a = 0; a < WORDS; a++) begin
            rd_addr = AW'(a);
            @(negedge clk);
            check({"R2 R8 sum ", tag}, rd_data, to_f32(exp_sum[a]));
        end
        flush = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int a = 0; a < WORDS; a++) exp_sum[a] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_addr = AW'(7);
        @(negedge clk);
        // R9 reset state
        check("R9 ready after reset", 32'(in_ready), 32'd1);
        check("R9 done low after reset", 32'(done), 32'd0);
        check("R9 R8 cleared word", rd_data, 32'd0);

        // table walk, back to back
        for (int i = 0; i < NVEC; i++) send(VEC[i][11:8], int'(VEC[i][7:0]));
        flush_and_read("table");

        // R1: distinct addresses, no stall expected
        stalls = 0;
        for (int i = 0; i < WORDS; i++) send(AW'(i), i + 1);
        in_valid = 1'b0;
        check("R1 stalls on distinct stream", 32'(stalls), 32'd0);
        flush_and_read("distinct");

        // R3 R4 R5 R6: long burst to one word fills the queue
        stalls = 0;
        for (int i = 0; i < 14; i++) send(AW'(6), 3 * i + 1);
        in_valid = 1'b0;
        check("R4 queue full pulled ready low", 32'(stalls > 0), 32'd1);
        flush = 1'b1;
        #1;
        check("R7 done low while queue holds entries", 32'(done), 32'd0);
        flush_and_read("burst R3 R5 R6");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule